// File: doc/BRIEF.md
# Serial Configuration Register with Strobe Latch

This block collects a wide configuration word from a three-wire serial port. The three wires are a data line, a shift clock and a strobe. It then presents the word in use as a parallel bus to downstream logic. All three pins are synchronised into the system clock domain. A rising edge on the synchronised shift clock moves one data bit into a shift register. The first bit received travels to the top bit position.

A separate active register holds the configuration that the rest of the chip uses. While the synchronised strobe is low, the active register holds its value. While the strobe is high, the active register tracks the shift register. A rising strobe therefore commits a freshly shifted word. Shifting with the strobe held high changes the active word bit by bit.

A synchronous reset loads a default word into both registers. Before any programming the block presents that default, which matches a strobe held high at power-up. A one-cycle pulse marks every cycle in which the active word takes a new value.

Top module: `cfg_serial_latch`

## Requirements
- R1: While reset is high and in the first cycle after it, `cfg_active` equals `DEFAULT_WORD` and `cfg_changed` is 0; the shift register also restarts from `DEFAULT_WORD`.
- R2: Bits enter the shift register at bit 0 and move one place toward the top on each shift. After `CFG_W` shifts, the first bit sent sits at bit `CFG_W-1` and the last at bit 0.
- R3: While the synchronised strobe is low, `cfg_active` keeps its value however many bits are shifted.
- R4: While the synchronised strobe is high, `cfg_active` equals the shift register contents of the previous cycle, so each shift reaches the active word.
- R5: A strobe rising after a full word has been shifted transfers that word unchanged to `cfg_active`.
- R6: `cfg_changed` is 1 in exactly those cycles in which `cfg_active` differs from its value in the previous cycle.
- R7: The shift register advances once per rising edge of the serial clock and holds in every other cycle, even while the serial clock stays high.
- R8: Each pin passes through `SYNC_STAGES` flops. With the default of 2, a serial clock rise driven before rising clock edge 1 updates the shift register at edge 3. With the strobe high, that update appears on `cfg_active` and `cfg_changed` at edge 4.
- R9: Re-raising the strobe when the shift register already equals `cfg_active` produces no `cfg_changed` pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous reset, active high |
| ser_data | input | 1 | Serial data pin |
| ser_clk | input | 1 | Serial shift clock pin, sampled by `clk` |
| ser_strobe | input | 1 | Strobe pin; high makes the active register follow the shift register |
| cfg_active | output | CFG_W | Active configuration word |
| cfg_changed | output | 1 | One-cycle pulse when `cfg_active` takes a new value |

## Verification
A serial clock rise driven on the pins reaches the shift register two synchroniser edges later, plus one edge for edge detection. It then reaches the active word one edge after that, and the change pulse rises together with the new active value. The strobe follows the same path and affects the active word on the third edge after a pin change. The bench keeps a queue of raw pin values three edges deep and updates its behavioural registers on every rising edge. It compares `cfg_active` and `cfg_changed` on the following falling edge. Directed checks count edges from a single serial clock rise to confirm the four-edge latency. They also count change pulses inside whole windows to check strobe commits, identical re-strobes and a held serial clock.

// File: rtl/cfg_serial_pkg.sv
package cfg_serial_pkg;
   typedef struct packed {
      logic data;
      logic sclk;
      logic strobe;
   } ser_pins_t;

   localparam ser_pins_t PINS_RESET = '{data: 1'b0, sclk: 1'b0, strobe: 1'b1};
endpackage

// File: rtl/cfg_serial_sync.sv
module cfg_serial_sync
   import cfg_serial_pkg::*;
#(
   parameter int unsigned STAGES = 2
) (
   input  logic      clk,
   input  logic      rst,
   input  ser_pins_t pins_raw,
   output ser_pins_t pins_sync
);
   if (STAGES < 2) begin : g_bad_stages
      $error("cfg_serial_sync: STAGES must be at least 2");
   end

   ser_pins_t chain [STAGES];

   for (genvar i = 0; i < STAGES; i++) begin : g_stage
      always_ff @(posedge clk) begin
         if (rst) begin
            chain[i] <= PINS_RESET;
         end else if (i == 0) begin
            chain[i] <= pins_raw;
         end else begin
            chain[i] <= chain[(i == 0) ? 0 : i - 1];
         end
      end
   end

   assign pins_sync = chain[STAGES-1];
endmodule

// File: rtl/cfg_serial_shift.sv
module cfg_serial_shift #(
   parameter int unsigned     W       = 160,
   parameter logic [W-1:0]    DEFAULT = '0
) (
   input  logic         clk,
   input  logic         rst,
   input  logic         sclk_s,
   input  logic         data_s,
   output logic [W-1:0] shreg
);
   if (W < 2) begin : g_bad_width
      $error("cfg_serial_shift: W must be at least 2");
   end

   logic sclk_prev;
   logic sclk_rise;

   assign sclk_rise = sclk_s & ~sclk_prev;

   always_ff @(posedge clk) begin
      if (rst) begin
         sclk_prev <= 1'b0;
         shreg     <= DEFAULT;
      end else begin
         sclk_prev <= sclk_s;
         if (sclk_rise) begin
            shreg <= {shreg[W-2:0], data_s};
         end
      end
   end

   // R7: no shift without a fresh serial clock edge
   assert_hold_no_edge_R7: assert property (@(posedge clk) disable iff (rst)
      !sclk_rise |=> $stable(shreg));
   // R7: a held-high serial clock gives at most one edge
   assert_single_edge_R7: assert property (@(posedge clk) disable iff (rst)
      sclk_rise |=> !sclk_rise);
endmodule

// File: rtl/cfg_serial_latch_stage.sv
module cfg_serial_latch_stage #(
   parameter int unsigned  W       = 160,
   parameter logic [W-1:0] DEFAULT = '0
) (
   input  logic         clk,
   input  logic         rst,
   input  logic         load,
   input  logic [W-1:0] shreg,
   output logic [W-1:0] active,
   output logic         changed
);
   logic [W-1:0] active_nxt;

   always_comb begin
      active_nxt = load ? shreg : active;
   end

   always_ff @(posedge clk) begin
      if (rst) begin
         active  <= DEFAULT;
         changed <= 1'b0;
      end else begin
         active  <= active_nxt;
         changed <= (active_nxt != active);
      end
   end

   assert_hold_strobe_low_R3: assert property (@(posedge clk) disable iff (rst)
      !load |=> $stable(active));
   assert_follow_strobe_high_R4: assert property (@(posedge clk) disable iff (rst)
      load |=> (active == $past(shreg)));
   assert_pulse_means_change_R6: assert property (@(posedge clk) disable iff (rst)
      changed |-> (active != $past(active)));
   assert_change_gives_pulse_R6: assert property (@(posedge clk) disable iff (rst)
      (active != $past(active)) |-> changed);
endmodule

// File: rtl/cfg_serial_latch.sv
module cfg_serial_latch
   import cfg_serial_pkg::*;
#(
   parameter int unsigned       CFG_W        = 160,
   parameter int unsigned       SYNC_STAGES  = 2,
   parameter logic [CFG_W-1:0]  DEFAULT_WORD = {(CFG_W/8){8'hC3}}
) (
   input  logic             clk,
   input  logic             rst,
   input  logic             ser_data,
   input  logic             ser_clk,
   input  logic             ser_strobe,
   output logic [CFG_W-1:0] cfg_active,
   output logic             cfg_changed
);
   ser_pins_t        pins_raw;
   ser_pins_t        pins_sync;
   logic [CFG_W-1:0] shreg;

   assign pins_raw = '{data: ser_data, sclk: ser_clk, strobe: ser_strobe};

   cfg_serial_sync #(.STAGES(SYNC_STAGES)) u_sync (
      .clk      (clk),
      .rst      (rst),
      .pins_raw (pins_raw),
      .pins_sync(pins_sync)
   );

   cfg_serial_shift #(.W(CFG_W), .DEFAULT(DEFAULT_WORD)) u_shift (
      .clk   (clk),
      .rst   (rst),
      .sclk_s(pins_sync.sclk),
      .data_s(pins_sync.data),
      .shreg (shreg)
   );

   cfg_serial_latch_stage #(.W(CFG_W), .DEFAULT(DEFAULT_WORD)) u_latch (
      .clk    (clk),
      .rst    (rst),
      .load   (pins_sync.strobe),
      .shreg  (shreg),
      .active (cfg_active),
      .changed(cfg_changed)
   );

   // R1: reset leaves the default word in place
   assert_reset_default_R1: assert property (@(posedge clk)
      rst |=> (cfg_active == DEFAULT_WORD) && !cfg_changed);
endmodule

// File: tb/cfg_serial_latch_bench.sv
module cfg_serial_latch_bench;
   localparam int CLK_PERIOD = 10;
   localparam int W = 160;
   localparam logic [W-1:0] DEF = {(W/8){8'hC3}};

   logic clk = 1'b0;
   logic rst = 1'b1;
   logic ser_data = 1'b0, ser_clk = 1'b0, ser_strobe = 1'b1;
   logic [W-1:0] cfg_active;
   logic cfg_changed;

   int checks = 0;
   int fails = 0;
   int pulses = 0;
   string phase = "R1";
   bit model_on = 1'b0;

   always #(CLK_PERIOD/2) clk = ~clk;

   cfg_serial_latch #(.CFG_W(W), .SYNC_STAGES(2), .DEFAULT_WORD(DEF)) u_cfg_serial_latch (
      .clk(clk), .rst(rst), .ser_data(ser_data), .ser_clk(ser_clk),
      .ser_strobe(ser_strobe), .cfg_active(cfg_active), .cfg_changed(cfg_changed)
   );

   // behavioural reference: raw pin history, index 0 newest
   logic [W-1:0] m_sh, m_act, nact;
   bit m_chg;
   bit qd[3], qc[3], qs[3];

   always @(posedge clk) begin
      if (rst) begin
         m_sh = DEF; m_act = DEF; m_chg = 0;
         for (int i = 0; i < 3; i++) begin qd[i] = 0; qc[i] = 0; qs[i] = 1; end
      end else begin
         nact  = qs[1] ? m_sh : m_act;
         m_chg = (nact != m_act);
         m_act = nact;
         if (qc[1] && !qc[2]) m_sh = {m_sh[W-2:0], qd[1]};
         qd[2] = qd[1]; qd[1] = qd[0]; qd[0] = ser_data;
         qc[2] = qc[1]; qc[1] = qc[0]; qc[0] = ser_clk;
         qs[2] = qs[1]; qs[1] = qs[0]; qs[0] = ser_strobe;
      end
   end

   always @(negedge clk) begin
      pulses += int'(cfg_changed);
      if (model_on) begin
         checks++;
         if (cfg_active !== m_act || cfg_changed !== m_chg) begin
            fails++;
            $display("FAIL %s model: active=%h chg=%b expected active=%h chg=%b",
                     phase, cfg_active, cfg_changed, m_act, m_chg);
         end
      end
   end

   task automatic check(bit ok, string req, logic [W-1:0] act, logic [W-1:0] exp);
      checks++;
      if (!ok) begin
         fails++;
         $display("FAIL %s: actual=%h expected=%h", req, act, exp);
      end
   endtask

   task automatic ticks(int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic send_bit(bit b);
      ser_data = b; ticks(3);
      ser_clk = 1'b1; ticks(3);
      ser_clk = 1'b0; ticks(3);
   endtask

   task automatic finish_run();
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      fails++;
      $display("FAIL watchdog: actual=hung expected=done");
      finish_run();
   end

   initial begin
      logic [W-1:0] w1;
      int lat;
      w1 = {5{32'h1234_5678}};
      ticks(5);
      check(cfg_active == DEF, "R1", cfg_active, DEF);
      check(cfg_changed == 1'b0, "R1", W'(cfg_changed), '0);
      rst = 1'b0; model_on = 1'b1;
      ticks(6);
      check(cfg_active == DEF, "R1", cfg_active, DEF);

      phase = "R3";
      ser_strobe = 1'b0; ticks(5);
      for (int i = W-1; i >= 0; i--) send_bit(w1[i]);
      check(cfg_active == DEF, "R3", cfg_active, DEF);

      phase = "R5"; pulses = 0;
      ser_strobe = 1'b1; ticks(8);
      check(cfg_active == w1, "R5", cfg_active, w1);
      check(cfg_active[W-1] == w1[W-1] && cfg_active[0] == w1[0], "R2",
            W'({cfg_active[W-1], cfg_active[0]}), W'({w1[W-1], w1[0]}));
      check(pulses == 1, "R6", W'(pulses), W'(1));

      phase = "R8";
      ser_data = 1'b1; ticks(3);
      ser_clk = 1'b1; lat = 0;
      for (int i = 1; i <= 6; i++) begin
         ticks(1);
         if (cfg_changed && lat == 0) lat = i;
      end
      check(lat == 4, "R8", W'(lat), W'(4));
      check(cfg_active == {w1[W-2:0], 1'b1}, "R4", cfg_active, {w1[W-2:0], 1'b1});

      phase = "R7"; pulses = 0;
      ticks(10);
      check(pulses == 0, "R7", W'(pulses), '0);
      ser_clk = 1'b0; ticks(3);

      phase = "R4"; pulses = 0;
      send_bit(1'b0); send_bit(1'b1); send_bit(1'b1);
      check(cfg_active == {w1[W-5:0], 4'b1011}, "R4", cfg_active, {w1[W-5:0], 4'b1011});
      check(pulses == 3, "R4", W'(pulses), W'(3));

      phase = "R9"; pulses = 0;
      ser_strobe = 1'b0; ticks(5);
      ser_strobe = 1'b1; ticks(8);
      check(pulses == 0, "R9", W'(pulses), '0);

      phase = "R1";
      ser_strobe = 1'b0; ticks(3);
      rst = 1'b1; ticks(4);
      check(cfg_active == DEF, "R1", cfg_active, DEF);
      rst = 1'b0; ticks(3);
      ser_strobe = 1'b1; ticks(8);
      check(cfg_active == DEF, "R1", cfg_active, DEF);
      finish_run();
   end
endmodule